// File: doc/BRIEF.md
# Receive Byte Ordering Aligner

This block sits on a receive path after byte deserialization, where each word carries two bytes. The low lane holds the earlier byte and the high lane the later one. On request, it makes sure that a chosen marker byte lands in the low lane. If the marker turns up in the high lane, the block inserts one pad byte into the stream, which moves every later byte by one lane. A marker that already sits in the low lane leaves the stream as it is.

A search starts on a rising edge of `order_req`. A request that stays high starts no second search. The marker value (`pattern`) and the filler value (`pad_byte`) are static configuration inputs. The datapath has one register stage, and `order_done` reports when ordering is complete.

The controller is a four-state machine:
- `ST_IDLE`: the state after reset. Data passes through unshifted and no search is active.
- `ST_HUNT`: the state while searching.
- `ST_DIRECT`: ordering is complete with no pad inserted.
- `ST_SHIFT`: ordering is complete with one pad inserted, so every word is rebuilt from two source words.

The transitions are:
- `T_REQ`: any state goes to `ST_HUNT` on a request edge.
- `T_LOW`: `ST_HUNT` goes to `ST_DIRECT` when the marker is in the low lane.
- `T_HIGH`: `ST_HUNT` goes to `ST_SHIFT` when the marker is only in the high lane.

Every other case holds the current state.

Top module: `rx_byte_order_align`

## Requirements
- R1: After reset, `out_valid`, `order_done` and `out_data` are 0. Until the first request edge, each valid word comes out unchanged one cycle later.
- R2: `out_valid` equals `in_valid` delayed by one clock cycle.
- R3: A rising edge of `order_req` starts a search. When that edge comes in a cycle without a valid word, `order_done` is 0 in the next cycle. Holding `order_req` high starts no further search.
- R4: During a search, a valid word whose low byte `[7:0]` equals `pattern` comes out unchanged. `order_done` is 1 in the cycle that word appears, and later words pass unshifted.
- R5: During a search, a valid word with `[15:8]` equal to `pattern` and `[7:0]` not equal to it comes out as `{pad_byte, in_data[7:0]}`. `order_done` is 1 in that same cycle.
- R6: After a pad has been inserted, each valid word comes out as `{in_data[7:0], previous valid word's [15:8]}`.
- R7: If both lanes equal `pattern`, the low lane wins and no pad is inserted.
- R8: During a search, valid words that match in neither lane come out unchanged, and `order_done` stays 0.
- R9: Cycles with `in_valid` low leave `out_data` unchanged. They advance no search and do not replace the held byte.
- R10: `order_done` stays 1 from completion until the next rising edge of `order_req`.
- R11: A new request edge while in the padded mode drops the shift. Words during the new search pass unshifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 16 | Input word, low lane earlier in time |
| order_req | input | 1 | Search request; its rising edge starts a search |
| pattern | input | 8 | Marker byte to place in the low lane |
| pad_byte | input | 8 | Filler byte inserted on realignment |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | 16 | Ordered output word |
| order_done | output | 1 | Ordering complete status |

## Verification
The bench builds the block with its default byte width of 8, so a 16-bit word. This width makes each lane compare and the pad and join byte orders directly visible in hex. The marker and pad values are chosen so that a wrong lane, a wrong priority or a missing held byte changes the output word. Bursts with gaps in `in_valid` test that the held byte survives idle cycles. A request edge during the padded mode tests the return to unshifted data.

// File: rtl/rbo_pkg.sv
package rbo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_DIRECT = 2'd2,
        ST_SHIFT  = 2'd3
    } rbo_state_e;

    typedef enum logic [1:0] {
        SEL_PASS = 2'd0,
        SEL_PAD  = 2'd1,
        SEL_JOIN = 2'd2
    } rbo_sel_e;
endpackage

// File: rtl/rbo_edge_det.sv
module rbo_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/rbo_lane_match.sv
module rbo_lane_match #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic [WORD_W-1:0] word,
    input  logic [BYTE_W-1:0] pattern,
    output logic [LANES-1:0]  hit
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit[g] = (word[g*BYTE_W +: BYTE_W] == pattern);
    end
endmodule

// File: rtl/rbo_out_mux.sv
module rbo_out_mux
    import rbo_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  rbo_sel_e          sel,
    input  logic [WORD_W-1:0] word,
    input  logic [BYTE_W-1:0] held,
    input  logic [BYTE_W-1:0] pad,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        unique case (sel)
            SEL_PAD:  result = {pad, word[BYTE_W-1:0]};
            SEL_JOIN: result = {word[BYTE_W-1:0], held};
            default:  result = word;
        endcase
    end
endmodule

// File: rtl/rx_byte_order_align.sv
module rx_byte_order_align
    import rbo_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int LANES  = 2,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              order_req,
    input  logic [BYTE_W-1:0] pattern,
    input  logic [BYTE_W-1:0] pad_byte,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              order_done
);
    rbo_state_e        state_q, state_d, base_st;
    rbo_sel_e          sel;
    logic              req_rise;
    logic              done_set;
    logic [LANES-1:0]  hit;
    logic [BYTE_W-1:0] held_q;
    logic [WORD_W-1:0] mux_out;

    rbo_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (order_req),
        .rise  (req_rise)
    );

    rbo_lane_match #(.BYTE_W(BYTE_W), .LANES(LANES)) u_match (
        .word    (in_data),
        .pattern (pattern),
        .hit     (hit)
    );

    rbo_out_mux #(.BYTE_W(BYTE_W)) u_mux (
        .sel    (sel),
        .word   (in_data),
        .held   (held_q),
        .pad    (pad_byte),
        .result (mux_out)
    );

    // Next-state and lane selection; a request edge (T_REQ) overrides the current state
    always_comb begin
        base_st  = req_rise ? ST_HUNT : state_q;
        state_d  = base_st;
        sel      = SEL_PASS;
        done_set = 1'b0;
        unique case (base_st)
            ST_IDLE, ST_DIRECT: sel = SEL_PASS;
            ST_HUNT: begin
                if (in_valid && hit[0]) begin          // T_LOW
                    state_d  = ST_DIRECT;
                    done_set = 1'b1;
                end else if (in_valid && hit[1]) begin // T_HIGH
                    state_d  = ST_SHIFT;
                    sel      = SEL_PAD;
                    done_set = 1'b1;
                end
            end
            ST_SHIFT: sel = SEL_JOIN;
            default:  sel = SEL_PASS;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            held_q     <= '0;
            order_done <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= mux_out;
                held_q   <= in_data[WORD_W-1 -: BYTE_W];
            end
            if (done_set)      order_done <= 1'b1;
            else if (req_rise) order_done <= 1'b0;
        end
    end
endmodule

// File: rtl/rbo_checker.sv
module rbo_checker #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              order_req,
    input logic [BYTE_W-1:0] pattern,
    input logic [BYTE_W-1:0] pad_byte,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              order_done
);
    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R3
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(order_req) && !in_valid) |=> !order_done);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order_done && !$rose(order_req)) |=> order_done);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(out_data));

    // R4 R5
    done_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(order_done) |-> (out_valid &&
            (out_data[BYTE_W-1:0] == pattern || out_data[WORD_W-1 -: BYTE_W] == pad_byte)));
endmodule

bind rx_byte_order_align rbo_checker #(.BYTE_W(BYTE_W)) u_rbo_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .order_req  (order_req),
    .pattern    (pattern),
    .pad_byte   (pad_byte),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .order_done (order_done)
);

// File: tb/test_rx_byte_order_align.sv
module test_rx_byte_order_align;
    localparam logic [7:0] PAT = 8'hBC;
    localparam logic [7:0] PAD = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        order_req = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        order_done;

    int n_cmp = 0;
    int n_bad = 0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    // model state
    int          m_mode = 0; // 0 idle, 1 hunt, 2 direct, 3 shift
    logic        m_req  = 1'b0;
    logic        m_done = 1'b0;
    logic [7:0]  m_held = '0;

    always #10 clk = ~clk;

    rx_byte_order_align i_rx_byte_order_align (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .order_req(order_req), .pattern(PAT), .pad_byte(PAD),
        .out_valid(out_valid), .out_data(out_data), .order_done(order_done)
    );

    task automatic check(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [15:0] d, input bit r, input string tag);
        logic [15:0] e;
        @(negedge clk);
        in_valid  = v;
        in_data   = d;
        order_req = r;
        if (r && !m_req) begin
            m_mode = 1;
            m_done = 1'b0;
        end
        m_req = r;
        if (v) begin
            e = d;
            if (m_mode == 1) begin
                if (d[7:0] == PAT) begin
                    m_mode = 2; m_done = 1'b1;
                end else if (d[15:8] == PAT) begin
                    m_mode = 3; m_done = 1'b1; e = {PAD, d[7:0]};
                end
            end else if (m_mode == 3) begin
                e = {d[7:0], m_held};
            end
            m_held = d[15:8];
            exp_q.push_back({m_done, e});
            tag_q.push_back(tag);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", {order_done, out_data}, 17'h0);
            end else begin
                logic [16:0] x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                check({order_done, out_data} == x, t, {order_done, out_data}, x);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 0 && order_done == 0 && out_data == 0, "R1",
              {out_valid, out_data}, 17'h0);
        rst_n = 1'b1;
        // R1 passthrough before any request
        drive(1, 16'hBC12, 0, "R1");
        drive(1, 16'h34BC, 0, "R1");
        // R8 search, no match
        drive(1, 16'h1111, 1, "R8");
        drive(1, 16'h2233, 1, "R8");
        // R4 low-lane hit
        drive(1, 16'h44BC, 1, "R4");
        drive(1, 16'hBC55, 1, "R3");   // level held: no new search
        drive(1, 16'h6677, 1, "R10");
        // R3 edge during idle cycle, R9 gaps
        drive(0, 16'h0000, 0, "R9");
        drive(0, 16'hBCBC, 1, "R3");
        drive(1, 16'h8899, 1, "R3");
        // R5 high-lane hit
        drive(1, 16'hBC11, 1, "R5");
        drive(1, 16'h2233, 1, "R6");
        drive(0, 16'hFFFF, 1, "R9");
        drive(0, 16'hBC00, 1, "R9");
        drive(1, 16'h4455, 1, "R6");
        drive(1, 16'h6677, 0, "R10");
        // R11 new request while shifted
        drive(1, 16'hA1B2, 1, "R11");
        drive(1, 16'hC3D4, 1, "R11");
        // R7 both lanes match
        drive(1, 16'hBCBC, 1, "R7");
        drive(1, 16'hBC01, 1, "R7");
        drive(0, 16'h0000, 0, "R2");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", 17'(exp_q.size()), 17'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule